// File: doc/BRIEF.md
# Protected sector-load program controller

This block is the write-side control of a word-wide nonvolatile memory model that is programmed one whole sector at a time. It samples the chip-select, write-strobe and output-enable lines (all active low), the address and the 16-bit input data on a fixed system clock. A write to the array is accepted only after a three-word unlock sequence. After the unlock, words of one sector go into a sector-sized buffer, in any order. The load window closes when no new write strobe arrives within a timeout. The block then runs a counted program period. At the end of that period it erases and rewrites the whole target sector from the buffer, one word per cycle.

While the block is busy, reads return a status word instead of array data. The status word holds the complement of the last loaded word on bits 7 and 15, and a toggle on bits 6 and 14. The address is split into a sector number above `WORD_W` bits and a word index below. The default array is 4096 words in 32 sectors of 128 words. Setting `ADDR_W` to 16 gives the full 64K-word array of 512 sectors. Array contents are undefined until a sector has first been programmed.

Top module: `sector_prog_ctrl`

## Requirements
- R1: After reset, `busy` is low and `dout_oe` is low.
- R2: A read is `ce_n` low, `oe_n` low and `we_n` high. During a read, `dout_oe` is high and, while not busy, `dout` shows the array word at `addr`. In every other case `dout_oe` is low.
- R3: Loading opens only after three valid writes in this order: AAAAh to address A1, 5555h to address A2, then A0A0h to address A1. A1 is the low `ADDR_W` bits of 5555h and A2 is the low `ADDR_W` bits of 2AAAh.
- R4: A write that breaks or lacks the unlock sequence stores nothing. It raises `busy` for about `PROG_CYC` cycles and then returns the sequencer to idle.
- R5: A write is counted only when `ce_n` and `we_n` are both low with `oe_n` high for at least `GLITCH` sampled cycles. The address is taken in the first such cycle and the data in the last one. With `oe_n` low, or with a shorter pulse, nothing happens and `busy` stays low.
- R6: Address bits above `WORD_W` select the sector and the low `WORD_W` bits select the word. Words may be loaded in any order. If a word is loaded twice, the last value wins.
- R7: The first loaded word fixes the target sector. Later words addressed to another sector are ignored.
- R8: The load window closes `WIN_CYC` cycles after the release of the last accepted write strobe, and `busy` rises a few cycles later.
- R9: After a commit, every word of the target sector that was not loaded reads FFFFh. Other sectors are unchanged.
- R10: While busy, a read returns the last loaded data with bits 7 and 15 inverted. All bits other than 6 and 14 are otherwise unchanged.
- R11: While busy, bits 6 and 14 of the status word invert between successive reads.
- R12: `busy` stays high through the program period and the sector rewrite. Once it falls, the array holds the new sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address (sector above WORD_W bits) |
| din | input | 16 | Write data |
| dout | output | 16 | Array word or status word while busy |
| dout_oe | output | 1 | High while a read is being presented |
| busy | output | 1 | High from window close until the sector rewrite ends |

## Verification
The assertions assume that the control lines and the data do not change in ways the sampler cannot follow. Data must be stable over the last sampled cycle of a write pulse, and the address must be stable over its first cycle. They also assume that reads are not started while a write pulse is active. The stimulus drives every input only on the falling clock edge. It holds address and data for the whole strobe pulse and releases the strobe lines together. It separates operations by at least one idle cycle, so each pulse is seen as one clean sampled interval.

// File: rtl/sector_prog_ctrl.sv
module sector_prog_ctrl #(
  parameter int ADDR_W   = 12,
  parameter int WORD_W   = 7,
  parameter int WIN_CYC  = 1500,
  parameter int PROG_CYC = 200000,
  parameter int GLITCH   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic              dout_oe,
  output logic              busy
);
  localparam int SEC_W     = ADDR_W - WORD_W;
  localparam int SEC_WORDS = 1 << WORD_W;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int WIN_W     = $clog2(WIN_CYC + 1);
  localparam int PRG_W     = $clog2(PROG_CYC + 1);
  localparam int PL_W      = $clog2(GLITCH + 2);
  localparam logic [15:0] KEY_A1_F = 16'h5555;
  localparam logic [15:0] KEY_A2_F = 16'h2AAA;
  localparam logic [ADDR_W-1:0] KEY_A1 = KEY_A1_F[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] KEY_A2 = KEY_A2_F[ADDR_W-1:0];

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_LOAD, S_PROG, S_COMMIT} st_t;

  logic              ce_s, we_s, oe_s, wr_d, rd_d;
  logic [ADDR_W-1:0] addr_s, ev_addr;
  logic [15:0]       din_s, ev_data, last_data;
  logic [PL_W-1:0]   plen;
  st_t               state;
  logic [WIN_W-1:0]  win_cnt;
  logic [PRG_W-1:0]  prg_cnt;
  logic [WORD_W-1:0] cidx;
  logic [SEC_W-1:0]  cur_sec;
  logic [SEC_WORDS-1:0] loaded;
  logic              tog;
  logic [15:0]       sbuf [SEC_WORDS];
  logic [15:0]       mem  [DEPTH];

  wire wr_s = ~ce_s & ~we_s & oe_s;
  wire rd_s = ~ce_s & ~oe_s & we_s;
  wire ev   = wr_d & ~wr_s & (plen == PL_W'(GLITCH));
  wire [SEC_W-1:0]  ev_sec  = ev_addr[ADDR_W-1:WORD_W];
  wire [WORD_W-1:0] ev_word = ev_addr[WORD_W-1:0];
  wire buf_we = (state == S_LOAD) & ev & (~|loaded | (ev_sec == cur_sec));
  wire mem_we = (state == S_COMMIT);

  assign busy    = (state == S_PROG) | (state == S_COMMIT);
  assign dout_oe = rd_s;
  assign dout    = busy ? {~last_data[15], tog, last_data[13:8], ~last_data[7], tog, last_data[5:0]}
                        : mem[addr_s];

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_s <= 1'b1; we_s <= 1'b1; oe_s <= 1'b1;
      addr_s <= '0; din_s <= '0;
      wr_d <= 1'b0; rd_d <= 1'b0; plen <= '0;
      ev_addr <= '0; ev_data <= '0;
    end else begin
      ce_s <= ce_n; we_s <= we_n; oe_s <= oe_n;
      addr_s <= addr; din_s <= din;
      wr_d <= wr_s; rd_d <= rd_s;
      if (wr_s) begin
        if (plen != PL_W'(GLITCH)) plen <= plen + PL_W'(1);
        if (!wr_d) ev_addr <= addr_s;
        ev_data <= din_s;
      end else begin
        plen <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; win_cnt <= '0; prg_cnt <= '0; cidx <= '0;
      cur_sec <= '0; loaded <= '0; last_data <= '0; tog <= 1'b0;
    end else begin
      if (busy && rd_d && !rd_s) tog <= ~tog;
      case (state)
        S_IDLE, S_U1, S_U2: if (ev) begin
          if (state == S_IDLE && ev_addr == KEY_A1 && ev_data == 16'hAAAA) state <= S_U1;
          else if (state == S_U1 && ev_addr == KEY_A2 && ev_data == 16'h5555) state <= S_U2;
          else if (state == S_U2 && ev_addr == KEY_A1 && ev_data == 16'hA0A0) begin
            state <= S_LOAD; win_cnt <= '0; loaded <= '0;
          end else begin
            state <= S_PROG; prg_cnt <= '0; loaded <= '0; last_data <= ev_data;
          end
        end
        S_LOAD: begin
          if (buf_we) begin
            loaded[ev_word] <= 1'b1;
            cur_sec   <= ev_sec;
            last_data <= ev_data;
            win_cnt   <= '0;
          end else if (!wr_s) begin
            if (win_cnt == WIN_W'(WIN_CYC - 1)) begin
              state <= S_PROG; prg_cnt <= '0;
            end else begin
              win_cnt <= win_cnt + WIN_W'(1);
            end
          end
        end
        S_PROG: begin
          if (prg_cnt == PRG_W'(PROG_CYC - 1)) begin
            state <= (|loaded) ? S_COMMIT : S_IDLE;
            cidx  <= '0;
          end else begin
            prg_cnt <= prg_cnt + PRG_W'(1);
          end
        end
        S_COMMIT: begin
          if (&cidx) begin
            state <= S_IDLE; loaded <= '0;
          end
          cidx <= cidx + WORD_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) sbuf[ev_word] <= ev_data;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[{cur_sec, cidx}] <= loaded[cidx] ? sbuf[cidx] : 16'hFFFF;
  end

  p_unlock_last_key_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOAD && $past(state) == S_U2) |-> $past(ev_data) == 16'hA0A0);

  p_write_needs_oe_high_r5: assert property (@(posedge clk) disable iff (rst)
    ev |-> $past(oe_s));

  p_sector_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOAD && |loaded) |=> cur_sec == $past(cur_sec));

  p_window_bound_r8: assert property (@(posedge clk) disable iff (rst)
    state == S_LOAD |-> win_cnt < WIN_W'(WIN_CYC));

  p_poll_inverts_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_s) |-> (dout[7] != last_data[7] && dout[15] != last_data[15]));

  p_array_write_busy_r12: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
endmodule

// File: tb/sector_prog_ctrl_tb.sv
module sector_prog_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12, WW = 7, WIN = 40, PRG = 60, GL = 2;
  localparam int NSEC = 1 << (AW - WW), NW = 1 << WW;
  localparam logic [AW-1:0] A1 = 12'h555, A2 = 12'hAAA;

  logic clk = 1'b0, rst = 1'b1, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0, dout;
  logic dout_oe, busy;
  int nchk = 0, nerr = 0;
  bit finished = 1'b0;
  logic [15:0] model [1 << AW];
  bit known [1 << AW];
  logic [15:0] tmp [NW];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sector_prog_ctrl #(.ADDR_W(AW), .WORD_W(WW), .WIN_CYC(WIN), .PROG_CYC(PRG), .GLITCH(GL)) u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .busy(busy));

  function automatic logic [15:0] exp_poll(input logic [15:0] d);
    return {~d[15], 1'b0, d[13:8], ~d[7], 1'b0, d[5:0]};
  endfunction

  function automatic logic [AW-1:0] mk(input int sec, input int w);
    return AW'((sec << WW) | w);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; din = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic read_word(input logic [AW-1:0] a, output logic [15:0] d, output logic oe);
    @(negedge clk); addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    repeat (2) @(negedge clk);
    d = dout; oe = dout_oe;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic unlock();
    write_word(A1, 16'hAAAA); write_word(A2, 16'h5555); write_word(A1, 16'hA0A0);
  endtask

  task automatic wait_level(input logic lvl, input int lim, output int n);
    n = 0;
    while (busy !== lvl && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic check_sector(input int sec, input string req);
    logic [15:0] d; logic oe;
    for (int w = 0; w < NW; w++) begin
      if (known[mk(sec, w)]) begin
        read_word(mk(sec, w), d, oe);
        chk(req, d, model[mk(sec, w)]);
      end
    end
  endtask

  task automatic commit_model(input int sec);
    for (int w = 0; w < NW; w++) begin model[mk(sec, w)] = tmp[w]; known[mk(sec, w)] = 1'b1; end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, r1, r2; logic oe; int n; int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < (1 << AW); i++) known[i] = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", 16'(busy), 16'h0);
    chk("R1 dout_oe", 16'(dout_oe), 16'h0);

    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; repeat (2) @(negedge clk);
    chk("R2 no oe with ce high", 16'(dout_oe), 16'h0);
    oe_n = 1'b1;

    // directed load of sector 3, out of order, repeated word
    for (int w = 0; w < NW; w++) tmp[w] = 16'hFFFF;
    unlock();
    write_word(mk(3, 5), 16'h1234);  tmp[5] = 16'h1234;
    write_word(mk(3, 0), 16'hABCD);  tmp[0] = 16'hABCD;
    write_word(mk(3, 127), 16'h0F0F); tmp[127] = 16'h0F0F;
    write_word(mk(3, 5), 16'h5678);  tmp[5] = 16'h5678;
    wait_level(1'b1, WIN + 20, n);
    chk("R8 window close timing", 16'((n >= WIN - 4) && (n <= WIN + 4)), 16'h1);
    read_word(mk(3, 9), r1, oe);
    read_word(mk(3, 9), r2, oe);
    chk("R2 oe during read", 16'(oe), 16'h1);
    chk("R10 status word", r1 & 16'hBFBF, exp_poll(16'h5678));
    chk("R11 toggle bit6", 16'(r1[6] ^ r2[6]), 16'h1);
    chk("R11 toggle bit14", 16'(r1[14] ^ r2[14]), 16'h1);
    chk("R12 busy during commit", 16'(busy), 16'h1);
    wait_level(1'b0, 2000, n);
    chk("R12 busy falls", 16'(busy), 16'h0);
    commit_model(3);
    check_sector(3, "R6 R9 sector readback");

    // sector 4 full random, then sector 3 unchanged
    for (int w = 0; w < NW; w++) tmp[w] = 16'hFFFF;
    unlock();
    for (int w = 0; w < NW; w++) begin
      d = 16'($urandom);
      write_word(mk(4, w), d); tmp[w] = d;
    end
    wait_level(1'b1, WIN + 20, n); wait_level(1'b0, 2000, n);
    commit_model(4);
    check_sector(4, "R6 full sector");
    check_sector(3, "R9 other sector kept");

    // foreign sector word ignored
    for (int w = 0; w < NW; w++) tmp[w] = 16'hFFFF;
    unlock();
    write_word(mk(5, 1), 16'h2222); tmp[1] = 16'h2222;
    write_word(mk(3, 0), 16'h0000);
    wait_level(1'b1, WIN + 20, n); wait_level(1'b0, 2000, n);
    commit_model(5);
    read_word(mk(3, 0), d, oe);
    chk("R7 foreign word ignored", d, model[mk(3, 0)]);
    check_sector(5, "R7 target sector");

    // write without unlock
    write_word(mk(3, 1), 16'h1111);
    chk("R4 busy after bare write", 16'(busy), 16'h1);
    wait_level(1'b0, 2000, n);
    chk("R4 dummy period", 16'((n >= PRG - 6) && (n <= PRG + 3)), 16'h1);
    read_word(mk(3, 1), d, oe);
    chk("R4 nothing stored", d, model[mk(3, 1)]);

    // broken second key
    write_word(A1, 16'hAAAA); write_word(A2, 16'h1234);
    chk("R3 broken key busy", 16'(busy), 16'h1);
    wait_level(1'b0, 2000, n);
    write_word(mk(3, 2), 16'h3333);
    wait_level(1'b0, 2000, n);
    read_word(mk(3, 2), d, oe);
    chk("R3 nothing stored after broken key", d, model[mk(3, 2)]);

    // short pulse and oe low inhibit
    @(negedge clk); addr = mk(3, 2); din = 16'h4444; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5 short pulse ignored", 16'(busy), 16'h0);
    oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
    repeat (4) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5 oe low inhibits", 16'(busy), 16'h0);

    // random sectors
    for (int t = 0; t < 8; t++) begin
      int sec, cnt;
      sec = $urandom_range(NSEC - 1, 0);
      cnt = $urandom_range(24, 1);
      for (int w = 0; w < NW; w++) tmp[w] = 16'hFFFF;
      unlock();
      for (int k = 0; k < cnt; k++) begin
        int w;
        w = $urandom_range(NW - 1, 0);
        d = 16'($urandom);
        write_word(mk(sec, w), d); tmp[w] = d;
        if ($urandom_range(3, 0) == 0) write_word(mk((sec + 1) % NSEC, w), ~d);
      end
      wait_level(1'b1, WIN + 20, n);
      chk("R8 random window", 16'(busy), 16'h1);
      wait_level(1'b0, 2000, n);
      commit_model(sec);
      check_sector(sec, "R9 random sector");
    end
    check_sector(4, "R9 sector 4 after random");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule